// File: doc/BRIEF.md
# Serial Per-Channel Trim Coefficient Loader

This block keeps one small trim code for each channel of a multichannel detector readout. The codes drive per-channel offset DACs. A serial bit stream, paced by its own slow serial clock, fills a serial-to-parallel register. A rising edge on a separate load strobe then copies that register into the storage slot of one channel. No address travels with the data. The target slot is the channel that the readout scan currently selects, so the host must place each load strobe inside the scan slot of the channel it wants to trim.

The serial clock, serial data and load strobe are asynchronous to the system clock. All three pass through a shared synchronizer, and the two strobes then go through rising-edge detectors that run on the system clock. Codes can be written once after reset or rewritten channel by channel while the scan is running. Every stored code is available at once on a flat bus, and a separate combinational read port returns the code of one channel. Code 0 means the low-reference end of the DAC range.

Top module: `trim_loader`

## Requirements
- R1: A synchronous active-high reset clears every stored code to 0 and clears the serial register to 0, so that a load issued straight after reset writes 0.
- R2: On each rising edge of the serial clock one data bit enters the serial register, MSB first. After six edges, bit 5 of the coefficient is the first of the last six bits received and bit 0 is the most recent.
- R3: A rising edge of the load strobe writes the serial register into the slot of the channel given by `scan_addr_i` at that time. The new code appears on the outputs after the third system-clock edge that samples the strobe high, counting the first such edge as edge 1.
- R4: A load changes only the addressed channel. Every other channel keeps its code.
- R5: Shifting serial bits without a load edge leaves every stored code unchanged.
- R6: Holding the load strobe high gives exactly one write. Changing `scan_addr_i` while the strobe stays high writes nothing to the new channel.
- R7: A falling edge of the serial clock shifts nothing. The data line may change while the serial clock stays high or low without effect.
- R8: `rd_code_o` always shows the stored code of channel `rd_addr_i`.
- R9: All channels can be loaded one after another while the scan address steps through them, and each keeps its own code.
- R10: When a load edge and a serial clock edge are detected on the same system clock, the load stores the register contents from before that shift.
- R11: Channel i occupies bits [i*6 +: 6] of `codes_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous; its rising edge samples data |
| ser_data_i | input | 1 | Serial coefficient data, MSB first |
| load_i | input | 1 | Load strobe, asynchronous; its rising edge writes a channel |
| scan_addr_i | input | 5 | Channel currently selected by the readout scan |
| rd_addr_i | input | 5 | Channel for the read port |
| codes_o | output | 192 | All stored codes, channel i at [i*6 +: 6] |
| rd_code_o | output | 6 | Stored code of channel `rd_addr_i` |

## Verification
The bench builds the block with its defaults: 32 channels, 6-bit codes and a two-stage synchronizer. This lets it visit every channel address, including the end values 0 and 31, and observe the two-clock synchronizer delay cycle by cycle. A behavioural model delays the sampled inputs by the same number of clocks and compares the whole code bus and the read port on every clock. Directed sequences then probe the corner cases: a strobe held high while the address moves, data changing while the serial clock is held, and a load that coincides with a shift.

// File: rtl/trim_pkg.sv
package trim_pkg;

    parameter int TRIM_NUM_CH  = 32;
    parameter int TRIM_CODE_W  = 6;
    parameter int TRIM_SYNC_N  = 2;

    // Bundle of asynchronous inputs crossing into the system clock domain
    typedef struct packed {
        logic load;
        logic sclk;
        logic data;
    } async_in_t;

    localparam int ASYNC_W = $bits(async_in_t);

    function automatic int addr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/trim_rise.sv
module trim_rise #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // A level held high yields a single-cycle pulse only
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rise_o[WIDTH-1] |=> !rise_o[WIDTH-1]);
endmodule

// File: rtl/trim_shift.sv
module trim_shift #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [CODE_W-1:0] par_o
);
    logic [CODE_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[CODE_W-2:0], bit_i};
    end

    assign par_o = sr_q;

    p_hold_no_shift_r7: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(par_o));
    p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> par_o[CODE_W-1:1] == $past(par_o[CODE_W-2:0]));
endmodule

// File: rtl/trim_bank.sv
module trim_bank #(
    parameter int NUM_CH = 32,
    parameter int CODE_W = 6,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [CODE_W-1:0]        wr_code_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [CODE_W-1:0]        rd_code_o,
    output logic [NUM_CH*CODE_W-1:0] codes_o
);
    logic [CODE_W-1:0] slot_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) slot_q[c] <= '0;
        end else if (wr_i && (int'(wr_addr_i) < NUM_CH)) begin
            slot_q[wr_addr_i] <= wr_code_i;
        end
    end

    always_comb begin
        rd_code_o = '0;
        if (int'(rd_addr_i) < NUM_CH) rd_code_o = slot_q[rd_addr_i];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign codes_o[c*CODE_W +: CODE_W] = slot_q[c];

        p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_i && int'(wr_addr_i) == c) |=> codes_o[c*CODE_W +: CODE_W] == $past(wr_code_i));
        p_others_kept_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_i && int'(wr_addr_i) != c) |=> $stable(codes_o[c*CODE_W +: CODE_W]));
    end

    p_no_write_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(codes_o));
endmodule

// File: rtl/trim_loader.sv
module trim_loader
    import trim_pkg::*;
#(
    parameter int NUM_CH = TRIM_NUM_CH,
    parameter int CODE_W = TRIM_CODE_W,
    parameter int SYNC_N = TRIM_SYNC_N,
    parameter int ADDR_W = addr_bits(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk_i,
    input  logic                     ser_data_i,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        scan_addr_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic [CODE_W-1:0]        rd_code_o
);
    async_in_t         raw, synced;
    logic [1:0]        strobe_rise;   // [1] load, [0] serial clock
    logic [CODE_W-1:0] coef;

    assign raw = '{load: load_i, sclk: ser_clk_i, data: ser_data_i};

    trim_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    trim_rise #(.WIDTH(2)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({synced.load, synced.sclk}),
        .rise_o (strobe_rise)
    );

    trim_shift #(.CODE_W(CODE_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (strobe_rise[0]),
        .bit_i   (synced.data),
        .par_o   (coef)
    );

    trim_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (strobe_rise[1]),
        .wr_addr_i (scan_addr_i),
        .wr_code_i (coef),
        .rd_addr_i (rd_addr_i),
        .rd_code_o (rd_code_o),
        .codes_o   (codes_o)
    );
endmodule

// File: tb/trim_loader_bench.sv
module trim_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int W   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, load = 1'b0;
    logic [4:0] scan_addr = '0, rd_addr = '0;
    logic [NCH*W-1:0] codes;
    logic [W-1:0] rd_code;

    int checks = 0, failures = 0;
    string phase = "R1";
    bit finished = 0;

    // Behavioural reference: inputs take effect two clocks after sampling
    int m_code [NCH];
    int m_sr;
    bit sc_h [3], dt_h [3], ld_h [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_loader u_trim_loader (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .load_i(load), .scan_addr_i(scan_addr), .rd_addr_i(rd_addr),
        .codes_o(codes), .rd_code_o(rd_code)
    );

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_code[i]) m_code[i] = 0;
            m_sr = 0;
            for (int k = 0; k < 3; k++) begin sc_h[k] = 0; dt_h[k] = 0; ld_h[k] = 0; end
        end else begin
            if (ld_h[1] && !ld_h[2]) m_code[scan_addr] = m_sr;
            if (sc_h[1] && !sc_h[2]) m_sr = ((m_sr << 1) | int'(dt_h[1])) & 63;
            sc_h[2] = sc_h[1]; sc_h[1] = sc_h[0]; sc_h[0] = ser_clk;
            dt_h[2] = dt_h[1]; dt_h[1] = dt_h[0]; dt_h[0] = ser_data;
            ld_h[2] = ld_h[1]; ld_h[1] = ld_h[0]; ld_h[0] = load;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int ch_code(input int c);
        return int'(codes[c*W +: W]);
    endfunction

    // Per-clock comparison against the model (R11 layout, R8 read port)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int c = 0; c < NCH; c++)
                if (ch_code(c) != m_code[c]) check(0, phase, ch_code(c), m_code[c]);
            checks++;
            check(int'(rd_code) == m_code[rd_addr], "R8", int'(rd_code), m_code[rd_addr]);
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ser_data = b; ticks(1);
        ser_clk = 1'b1; ticks(2);
        ser_clk = 1'b0; ticks(2);
    endtask

    task automatic send_code(input int v);
        for (int i = W-1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic do_load(input int ch);
        scan_addr = 5'(ch); ticks(1);
        load = 1'b1; ticks(2);
        load = 1'b0; ticks(3);
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        ticks(1);
        // R1: reset state
        check(codes == '0, "R1", int'(codes[31:0]), 0);
        do_load(4);
        check(ch_code(4) == 0, "R1", ch_code(4), 0);

        // R2 + R3: MSB-first assembly and exact latency
        phase = "R3";
        send_code(6'h2D);
        scan_addr = 5'd7; ticks(1);
        load = 1'b1; ticks(1);       // edge 1 samples high
        ticks(1);                    // after edge 2
        check(ch_code(7) == 0, "R3", ch_code(7), 0);
        ticks(1);                    // after edge 3
        check(ch_code(7) == 6'h2D, "R2", ch_code(7), 6'h2D);
        load = 1'b0; ticks(3);
        // R4: neighbours untouched
        check(ch_code(6) == 0 && ch_code(8) == 0, "R4", ch_code(8), 0);

        // R5: shifting alone changes nothing
        phase = "R5";
        send_code(6'h3F);
        check(ch_code(7) == 6'h2D, "R5", ch_code(7), 6'h2D);

        // R6: held strobe, address moves
        phase = "R6";
        send_code(6'h11);
        scan_addr = 5'd10; ticks(1);
        load = 1'b1; ticks(4);
        scan_addr = 5'd11; ticks(6);
        load = 1'b0; ticks(3);
        check(ch_code(10) == 6'h11, "R6", ch_code(10), 6'h11);
        check(ch_code(11) == 0, "R6", ch_code(11), 0);

        // R7: data wiggles while serial clock held, falling edges ignored
        phase = "R7";
        for (int i = W-1; i >= 0; i--) begin
            ser_data = 1'(6'h25 >> i); ticks(1);
            ser_clk = 1'b1; ticks(3);
            ser_data = ~ser_data; ticks(3);
            ser_clk = 1'b0; ticks(2);
            ser_data = ~ser_data; ticks(2);
        end
        do_load(12);
        check(ch_code(12) == 6'h25, "R7", ch_code(12), 6'h25);

        // R10: load and shift detected together store pre-shift value
        phase = "R10";
        scan_addr = 5'd13; ser_data = 1'b0; ticks(1);
        load = 1'b1; ser_clk = 1'b1; ticks(3);
        load = 1'b0; ser_clk = 1'b0; ticks(3);
        check(ch_code(13) == 6'h25, "R10", ch_code(13), 6'h25);
        do_load(14);
        check(ch_code(14) == 6'h0A, "R10", ch_code(14), 6'h0A);

        // R9: write every channel while the scan steps
        phase = "R9";
        for (int c = 0; c < NCH; c++) begin
            send_code((c * 7 + 3) & 63);
            do_load(c);
        end
        for (int c = 0; c < NCH; c++)
            check(ch_code(c) == ((c * 7 + 3) & 63), "R9", ch_code(c), (c * 7 + 3) & 63);

        // R8 / R11: read port sweep
        phase = "R8";
        for (int c = 0; c < NCH; c++) begin
            rd_addr = 5'(c); #1;
            check(int'(rd_code) == ((c * 7 + 3) & 63), "R8", int'(rd_code), (c * 7 + 3) & 63);
            check(int'(codes[c*W +: W]) == ((c * 7 + 3) & 63), "R11", ch_code(c), (c * 7 + 3) & 63);
            ticks(1);
        end

        // R1: reset during operation
        phase = "R1";
        rst = 1'b1; ticks(2);
        check(codes == '0, "R1", int'(codes[31:0]), 0);
        rst = 1'b0; ticks(2);
        do_load(31);
        check(ch_code(31) == 0, "R1", ch_code(31), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule